// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a memory-mapped mailbox between a host processor and an embedded power-management controller. The host reaches it over a simple 32-bit register bus with one cycle of read latency. Through that bus the host can:

- fill a four-word input buffer;
- set a source pointer and a destination pointer;
- post a command word.

Posting the command marks the mailbox busy and sends a one-cycle doorbell to the controller side.

The controller side (the responder) sees the latched command, both pointers and the input buffer. It can load words into a four-word result buffer. It finishes a transaction with a done strobe that carries an error flag and an 8-bit error code. Completion clears busy and sets the interrupt-pending status bit. If the command word asked for an interrupt, the host interrupt line is raised; the host clears it by writing 1 to the pending bit of the status register.

The command word carries:

- the command code in its low bits;
- bit 8, which requests an interrupt on completion;
- the sub-command from bit 12;
- the input length in bytes from bit 16.

The mailbox passes this word through to the responder unchanged.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every readable register returns zero. The source pointer (offset 0x08), destination pointer (0x0C) and command (0x00) read back the last value written. A host read returns data in the cycle after the read strobe.
- R2: A host write to the command register (0x00) while not busy latches the word onto `rsp_cmd`. It sets status bit 0 (busy) and drives `rsp_doorbell` high for exactly one cycle, in the cycle after the write.
- R3: A command write while busy is ignored. The latched command is unchanged, no doorbell is sent, and the sticky overrun flag in status bit 3 is set.
- R4: A done strobe while busy clears busy in the cycle it is taken. In that same cycle it latches the error flag into status bit 1 and the error code into status bits 23:16. The code is zero when the error flag is low.
- R5: A command accepted while not busy clears the previous error bit, error code and interrupt-pending bit.
- R6: Every completion sets status bit 2 (interrupt pending). `h_irq` is high exactly when that bit is set and bit 8 of the last accepted command was 1.
- R7: A host write to the status register (0x04) with bit 2 set clears the pending bit and drops `h_irq`. A status write with bit 2 clear leaves the pending bit unchanged.
- R8: Host writes to 0x80+4i (i = 0..3) fill input-buffer word i, which the responder reads on `rsp_wbuf_data` by selecting `rsp_wbuf_idx` = i.
- R9: Responder loads of result word i are read by the host at 0x90+4i. Host writes to 0x90–0x9F have no effect.
- R10: Host reads of unmapped offsets return zero.
- R11: A done strobe while not busy is ignored and leaves the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_wen | input | 1 | Host write strobe |
| h_ren | input | 1 | Host read strobe |
| h_addr | input | 8 | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid the cycle after `h_ren` |
| h_irq | output | 1 | Host interrupt |
| rsp_doorbell | output | 1 | One-cycle pulse when a command is accepted |
| rsp_cmd | output | 32 | Latched command word |
| rsp_src | output | 32 | Source pointer |
| rsp_dst | output | 32 | Destination pointer |
| rsp_wbuf_idx | input | 2 | Responder input-buffer word select |
| rsp_wbuf_data | output | 32 | Selected input-buffer word |
| rsp_rbuf_we | input | 1 | Responder result-buffer write enable |
| rsp_rbuf_idx | input | 2 | Result-buffer word select |
| rsp_rbuf_data | input | 32 | Result-buffer write data |
| rsp_done | input | 1 | Completion strobe |
| rsp_err | input | 1 | Error flag taken with `rsp_done` |
| rsp_err_code | input | 8 | Error code taken with `rsp_done` |

## Verification
The hardest states to reach from the ports are those that overlap one transaction with the remains of the previous one. Examples are a command posted while busy, a stale error code and pending bit still present when the next command is accepted, and a done strobe with no transaction open. The stimulus reaches them by deliberately holding the responder back. It posts a second command before completing the first, completes one command with an error and leaves it unacknowledged before posting the next, and fires an extra done strobe after acknowledging. A queue of expected read values checks the status word after each of these steps.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int BUF_WORDS = 4,
  parameter int ERR_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         h_wen,
  input  logic                         h_ren,
  input  logic [AW-1:0]                h_addr,
  input  logic [DW-1:0]                h_wdata,
  output logic [DW-1:0]                h_rdata,
  output logic                         h_irq,
  output logic                         rsp_doorbell,
  output logic [DW-1:0]                rsp_cmd,
  output logic [DW-1:0]                rsp_src,
  output logic [DW-1:0]                rsp_dst,
  input  logic [$clog2(BUF_WORDS)-1:0] rsp_wbuf_idx,
  output logic [DW-1:0]                rsp_wbuf_data,
  input  logic                         rsp_rbuf_we,
  input  logic [$clog2(BUF_WORDS)-1:0] rsp_rbuf_idx,
  input  logic [DW-1:0]                rsp_rbuf_data,
  input  logic                         rsp_done,
  input  logic                         rsp_err,
  input  logic [ERR_W-1:0]             rsp_err_code
);

  localparam int IW        = $clog2(BUF_WORDS);
  localparam int BUF_BYTES = 4 * BUF_WORDS;
  localparam logic [AW-1:0] OFF_CMD  = AW'(8'h00);
  localparam logic [AW-1:0] OFF_STAT = AW'(8'h04);
  localparam logic [AW-1:0] OFF_SRC  = AW'(8'h08);
  localparam logic [AW-1:0] OFF_DST  = AW'(8'h0C);
  localparam logic [AW-1:0] OFF_WBUF = AW'(8'h80);
  localparam logic [AW-1:0] OFF_RBUF = AW'(8'h90);
  localparam int IRQ_REQ_BIT = 8;
  localparam int CODE_LSB    = 16;

  logic [DW-1:0]    cmd_q, src_q, dst_q;
  logic [DW-1:0]    wbuf [BUF_WORDS];
  logic [DW-1:0]    rbuf [BUF_WORDS];
  logic             busy, err, pend, ovr, bell;
  logic [ERR_W-1:0] code;
  logic [DW-1:0]    stat_w, rd_mux;

  logic wsel_cmd, wsel_stat, in_wbuf, in_rbuf, take_cmd, take_done;
  logic [IW-1:0] wbuf_idx, rbuf_idx;
  logic [AW-1:0] wbuf_off, rbuf_off;

  assign wsel_cmd  = h_wen && (h_addr == OFF_CMD);
  assign wsel_stat = h_wen && (h_addr == OFF_STAT);
  assign take_cmd  = wsel_cmd && !busy;
  assign take_done = rsp_done && busy;

  assign wbuf_off = h_addr - OFF_WBUF;
  assign rbuf_off = h_addr - OFF_RBUF;
  assign in_wbuf  = (h_addr >= OFF_WBUF) && (wbuf_off < AW'(BUF_BYTES));
  assign in_rbuf  = (h_addr >= OFF_RBUF) && (rbuf_off < AW'(BUF_BYTES));
  assign wbuf_idx = wbuf_off[IW+1:2];
  assign rbuf_idx = rbuf_off[IW+1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      busy  <= 1'b0;
      bell  <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      bell <= take_cmd;
      if (take_cmd) begin
        cmd_q <= h_wdata;
        busy  <= 1'b1;
      end else if (take_done) begin
        busy <= 1'b0;
      end
      if (wsel_cmd && busy) ovr <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err  <= 1'b0;
      code <= '0;
      pend <= 1'b0;
    end else if (take_cmd) begin
      err  <= 1'b0;
      code <= '0;
      pend <= 1'b0;
    end else if (take_done) begin
      err  <= rsp_err;
      code <= rsp_err ? rsp_err_code : '0;
      pend <= 1'b1;
    end else if (wsel_stat && h_wdata[2]) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (h_wen) begin
      if (h_addr == OFF_SRC) src_q <= h_wdata;
      if (h_addr == OFF_DST) dst_q <= h_wdata;
    end
  end

  for (genvar g = 0; g < BUF_WORDS; g++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wbuf[g] <= '0;
        rbuf[g] <= '0;
      end else begin
        if (h_wen && in_wbuf && wbuf_idx == IW'(g)) wbuf[g] <= h_wdata;
        if (rsp_rbuf_we && rsp_rbuf_idx == IW'(g)) rbuf[g] <= rsp_rbuf_data;
      end
    end
  end

  always_comb begin
    stat_w = '0;
    stat_w[0] = busy;
    stat_w[1] = err;
    stat_w[2] = pend;
    stat_w[3] = ovr;
    stat_w[CODE_LSB +: ERR_W] = code;
  end

  always_comb begin
    rd_mux = '0;
    if (h_addr == OFF_CMD)       rd_mux = cmd_q;
    else if (h_addr == OFF_STAT) rd_mux = stat_w;
    else if (h_addr == OFF_SRC)  rd_mux = src_q;
    else if (h_addr == OFF_DST)  rd_mux = dst_q;
    else if (in_wbuf)            rd_mux = wbuf[wbuf_idx];
    else if (in_rbuf)            rd_mux = rbuf[rbuf_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     h_rdata <= '0;
    else if (h_ren) h_rdata <= rd_mux;
  end

  assign h_irq         = pend && cmd_q[IRQ_REQ_BIT];
  assign rsp_doorbell  = bell;
  assign rsp_cmd       = cmd_q;
  assign rsp_src       = src_q;
  assign rsp_dst       = dst_q;
  assign rsp_wbuf_data = wbuf[rsp_wbuf_idx];

  // R2
  doorbell_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_doorbell |=> !rsp_doorbell);
  // R2
  busy_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wen && h_addr == OFF_CMD && !busy) |=> (busy && rsp_doorbell));
  // R3
  cmd_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wen && h_addr == OFF_CMD && busy) |=> (ovr && !rsp_doorbell && $stable(rsp_cmd)));
  // R4
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && busy && !h_wen) |=> (!busy && pend && err == $past(rsp_err)));
  // R6
  irq_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && busy && rsp_cmd[IRQ_REQ_BIT]) |=> h_irq);
  // R7
  pend_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wen && h_addr == OFF_STAT && h_wdata[2] && !rsp_done) |=> (!pend && !h_irq));
  // R11
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !busy && !h_wen) |=> $stable(stat_w));

endmodule

// File: tb/ipc_mailbox_tb_top.sv
module ipc_mailbox_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_wen = 1'b0, h_ren = 1'b0;
  logic [7:0] h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic h_irq, rsp_doorbell;
  logic [31:0] rsp_cmd, rsp_src, rsp_dst, rsp_wbuf_data;
  logic [1:0] rsp_wbuf_idx = '0, rsp_rbuf_idx = '0;
  logic rsp_rbuf_we = 1'b0;
  logic [31:0] rsp_rbuf_data = '0;
  logic rsp_done = 1'b0, rsp_err = 1'b0;
  logic [7:0] rsp_err_code = '0;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;
  bit finished = 0;

  always #10 clk = ~clk;

  ipc_mailbox dut_i (
    .clk(clk), .rst_n(rst_n), .h_wen(h_wen), .h_ren(h_ren), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq), .rsp_doorbell(rsp_doorbell),
    .rsp_cmd(rsp_cmd), .rsp_src(rsp_src), .rsp_dst(rsp_dst),
    .rsp_wbuf_idx(rsp_wbuf_idx), .rsp_wbuf_data(rsp_wbuf_data),
    .rsp_rbuf_we(rsp_rbuf_we), .rsp_rbuf_idx(rsp_rbuf_idx), .rsp_rbuf_data(rsp_rbuf_data),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_err_code(rsp_err_code));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= h_ren;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard actual=%h expected=none", h_rdata);
      end else begin
        check(tag_q.pop_front(), h_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic hwr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); h_wen = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk); h_wen = 1'b0;
  endtask

  task automatic hrd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk); h_ren = 1'b1; h_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); h_ren = 1'b0;
  endtask

  task automatic done(logic e, logic [7:0] c);
    @(negedge clk); rsp_done = 1'b1; rsp_err = e; rsp_err_code = c;
    @(negedge clk); rsp_done = 1'b0; rsp_err = 1'b0; rsp_err_code = '0;
  endtask

  task automatic rload(int i, logic [31:0] d);
    @(negedge clk); rsp_rbuf_we = 1'b1; rsp_rbuf_idx = 2'(i); rsp_rbuf_data = d;
    @(negedge clk); rsp_rbuf_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    hrd(8'h04, 32'h0, "R1 status reset");
    hrd(8'h00, 32'h0, "R1 cmd reset");
    check("R1 irq reset", {31'b0, h_irq}, 32'h0);
    hwr(8'h08, 32'h1234_5678);
    hwr(8'h0C, 32'hCAFE_0000);
    hrd(8'h08, 32'h1234_5678, "R1 src readback");
    hrd(8'h0C, 32'hCAFE_0000, "R1 dst readback");
    check("R1 src port", rsp_src, 32'h1234_5678);
    // R8 input buffer
    for (int i = 0; i < 4; i++) hwr(8'h80 + 8'(4*i), 32'hA0A0_0000 + i);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); rsp_wbuf_idx = 2'(i); #1;
      check("R8 wbuf word", rsp_wbuf_data, 32'hA0A0_0000 + i);
    end
    hrd(8'h88, 32'hA0A0_0002, "R8 wbuf host read");
    // R2 accepted command with irq request
    hwr(8'h00, 32'h0003_1105);
    check("R2 doorbell high", {31'b0, rsp_doorbell}, 32'h1);
    check("R2 cmd port", rsp_cmd, 32'h0003_1105);
    @(negedge clk);
    check("R2 doorbell single", {31'b0, rsp_doorbell}, 32'h0);
    hrd(8'h04, 32'h1, "R2 busy set");
    // R3 command while busy
    hwr(8'h00, 32'h0000_AAAA);
    check("R3 no doorbell", {31'b0, rsp_doorbell}, 32'h0);
    check("R3 cmd kept", rsp_cmd, 32'h0003_1105);
    hrd(8'h04, 32'h9, "R3 overrun set");
    // R9 result buffer
    for (int i = 0; i < 4; i++) rload(i, 32'h5500_0010 + i);
    hwr(8'h94, 32'hDEAD_BEEF);
    done(1'b0, 8'h00);
    hrd(8'h04, 32'hC, "R4 busy cleared no err");
    check("R6 irq raised", {31'b0, h_irq}, 32'h1);
    for (int i = 0; i < 4; i++) hrd(8'h90 + 8'(4*i), 32'h5500_0010 + i, "R9 rbuf read");
    // R7 W1C
    hwr(8'h04, 32'h0000_0000);
    hrd(8'h04, 32'hC, "R7 write zero keeps pend");
    check("R7 irq kept", {31'b0, h_irq}, 32'h1);
    hwr(8'h04, 32'h0000_0004);
    hrd(8'h04, 32'h8, "R7 pend cleared");
    check("R7 irq dropped", {31'b0, h_irq}, 32'h0);
    // R4 error completion, no irq request
    hwr(8'h00, 32'h0000_0002);
    done(1'b1, 8'h05);
    hrd(8'h04, 32'h0005_000E, "R4 err and code");
    check("R6 irq gated by flag", {31'b0, h_irq}, 32'h0);
    // R5 new command clears stale state
    hwr(8'h00, 32'h0000_0107);
    hrd(8'h04, 32'h9, "R5 cleared on new cmd");
    check("R5 irq low", {31'b0, h_irq}, 32'h0);
    done(1'b0, 8'h00);
    hwr(8'h04, 32'h4);
    // R11 done while idle
    done(1'b1, 8'h33);
    hrd(8'h04, 32'h8, "R11 idle done ignored");
    check("R11 irq low", {31'b0, h_irq}, 32'h0);
    // R10 unmapped
    hrd(8'h40, 32'h0, "R10 unmapped 0x40");
    hrd(8'hA0, 32'h0, "R10 unmapped 0xA0");
    @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule